// File: doc/BRIEF.md
# Two-Register Instruction Prefetch Queue

The block buffers instruction halfwords between the bus and the execution unit. A fetch delivers either one 16-bit word or a 32-bit pair. A pair is split across two input holding registers, a primary and a secondary one. Neither holding register decodes anything. The first stage whose contents are used is the decode register, which also serves as the source of immediate operands. Behind it sits the residual register, which keeps the opcode for the rest of execution. The decode register drains the holding stage with a fixed priority: the primary register always goes before the secondary one.

Fetches enter over a valid/ready handshake. A word transfers on a rising edge where `fetch_valid` and `fetch_ready` are both high. `fetch_ready` is high only while both holding registers are empty, or while `flush` is asserted. A fetch that is offered while ready is low is not taken, and the source must hold it. `advance` and `flush` are plain control pins with no handshake. The outputs are state only and do not wait on a consumer.

Top module: `pq_top`

## Requirements
- R1: After reset, and while `rst_n` is low, `dec_valid` and `res_valid` are 0 and `fetch_ready` is 1.
- R2: `fetch_ready` is 1 exactly when both holding registers are empty or `flush` is 1. A `fetch_valid` offered while `fetch_ready` is 0 is ignored and changes no output.
- R3: A narrow fetch (`fetch_wide`=0) loads `fetch_data[15:0]` into the primary register only.
- R4: A wide fetch (`fetch_wide`=1) puts `fetch_data[31:16]` into the primary register and `fetch_data[15:0]` into the secondary register. The primary word reaches the decode register before the secondary word.
- R5: While the decode register is empty, it takes a word from a valid holding register on the next edge. A word accepted on edge k therefore appears on `dec_word` after edge k+1.
- R6: An `advance` while `dec_valid`=1 copies `dec_word` into `res_word`, sets `res_valid`, and refills the decode register from the holding stage by the R4 priority. If the holding stage is empty, `dec_valid` becomes 0.
- R7: An `advance` while `dec_valid`=0 leaves `res_valid` and `res_word` unchanged.
- R8: A `flush` clears every valid flag on the next edge.
- R9: A fetch offered in the same cycle as `flush` is accepted. After the clear it sits in the holding stage, so `fetch_ready` is 0 after the edge if no flush follows.
- R10: Without `advance` or `flush`, a valid decode word and the residual register hold their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_valid | input | 1 | Fetch data is offered |
| fetch_ready | output | 1 | Holding stage can take a fetch |
| fetch_wide | input | 1 | Offered fetch is a 32-bit pair |
| fetch_data | input | 32 | Fetch data, upper halfword first for a pair |
| flush | input | 1 | Discard all queued words |
| advance | input | 1 | Execution consumes the decode word |
| dec_valid | output | 1 | Decode register holds a word |
| dec_word | output | 16 | Decode register contents / immediate data |
| res_valid | output | 1 | Residual register holds a word |
| res_word | output | 16 | Residual opcode word |

## Verification
Two pairs of events can land in the same cycle. In the first, a flush meets a fetch, and the fetch must survive the clear that the flush performs. In the second, an advance meets a fetch: the decode register empties while the fetch fills the holding stage. The stimulus table provokes both overlaps on purpose. The result is judged after the edge from `dec_valid`, `res_word` and `fetch_ready`, and again one edge later when the new word reaches `dec_word`. A directed test also checks that raising `flush` makes `fetch_ready` high before the edge, while the holding stage is still full.

// File: rtl/pq_pkg.sv
package pq_pkg;

  // Source chosen to refill the decode register
  typedef enum logic [1:0] {
    FILL_NONE = 2'd0,
    FILL_PRIM = 2'd1,
    FILL_SEC  = 2'd2
  } fill_sel_e;

endpackage

// File: rtl/pq_input_stage.sv
module pq_input_stage #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush,
  input  logic           load,
  input  logic           load_wide,
  input  logic [2*W-1:0] load_data,
  input  logic           take_prim,
  input  logic           take_sec,
  output logic           prim_v,
  output logic [W-1:0]   prim_w,
  output logic           sec_v,
  output logic [W-1:0]   sec_w
);

  localparam int DW = 2 * W;

  logic [W-1:0] hi_half;
  logic [W-1:0] lo_half;

  assign hi_half = load_data[DW-1:W];
  assign lo_half = load_data[W-1:0];

  // Primary holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prim_v <= 1'b0;
      prim_w <= '0;
    end else begin
      if (flush || take_prim) prim_v <= 1'b0;
      if (load) begin
        prim_v <= 1'b1;
        prim_w <= load_wide ? hi_half : lo_half;
      end
    end
  end

  // Secondary holding register, only written by a pair
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_v <= 1'b0;
      sec_w <= '0;
    end else begin
      if (flush || take_sec) sec_v <= 1'b0;
      if (load && load_wide) begin
        sec_v <= 1'b1;
        sec_w <= lo_half;
      end
    end
  end

endmodule

// File: rtl/pq_steer.sv
module pq_steer
  import pq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         need_fill,
  input  logic         flush,
  input  logic         prim_v,
  input  logic [W-1:0] prim_w,
  input  logic         sec_v,
  input  logic [W-1:0] sec_w,
  output fill_sel_e    sel,
  output logic         fill_v,
  output logic [W-1:0] fill_w,
  output logic         take_prim,
  output logic         take_sec
);

  // Fixed priority: primary before secondary
  always_comb begin
    sel = FILL_NONE;
    if (prim_v)     sel = FILL_PRIM;
    else if (sec_v) sel = FILL_SEC;
  end

  always_comb begin
    fill_v = 1'b0;
    fill_w = '0;
    unique case (sel)
      FILL_PRIM: begin fill_v = 1'b1; fill_w = prim_w; end
      FILL_SEC:  begin fill_v = 1'b1; fill_w = sec_w;  end
      default:   begin fill_v = 1'b0; fill_w = '0;     end
    endcase
  end

  assign take_prim = need_fill && !flush && (sel == FILL_PRIM);
  assign take_sec  = need_fill && !flush && (sel == FILL_SEC);

endmodule

// File: rtl/pq_decode_stage.sv
module pq_decode_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         advance,
  input  logic         fill_v,
  input  logic [W-1:0] fill_w,
  output logic         need_fill,
  output logic         dec_v,
  output logic [W-1:0] dec_w,
  output logic         res_v,
  output logic [W-1:0] res_w
);

  logic adv_eff;

  assign adv_eff   = advance && dec_v;
  assign need_fill = !dec_v || adv_eff;

  // Decode register: first stage in use
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_v <= 1'b0;
      dec_w <= '0;
    end else if (flush) begin
      dec_v <= 1'b0;
    end else if (need_fill) begin
      dec_v <= fill_v;
      if (fill_v) dec_w <= fill_w;
    end
  end

  // Residual register: keeps the opcode during execution
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_v <= 1'b0;
      res_w <= '0;
    end else if (flush) begin
      res_v <= 1'b0;
    end else if (adv_eff) begin
      res_v <= 1'b1;
      res_w <= dec_w;
    end
  end

endmodule

// File: rtl/pq_top.sv
module pq_top #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fetch_valid,
  output logic           fetch_ready,
  input  logic           fetch_wide,
  input  logic [2*W-1:0] fetch_data,
  input  logic           flush,
  input  logic           advance,
  output logic           dec_valid,
  output logic [W-1:0]   dec_word,
  output logic           res_valid,
  output logic [W-1:0]   res_word
);

  import pq_pkg::*;

  logic          prim_v, sec_v;
  logic [W-1:0]  prim_w, sec_w;
  logic          need_fill, fill_v, take_prim, take_sec;
  logic [W-1:0]  fill_w;
  logic          accept;
  fill_sel_e     sel;

  assign fetch_ready = (!prim_v && !sec_v) || flush;
  assign accept      = fetch_valid && fetch_ready;

  pq_input_stage #(.W(W)) u_in (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .load      (accept),
    .load_wide (fetch_wide),
    .load_data (fetch_data),
    .take_prim (take_prim),
    .take_sec  (take_sec),
    .prim_v    (prim_v),
    .prim_w    (prim_w),
    .sec_v     (sec_v),
    .sec_w     (sec_w)
  );

  pq_steer #(.W(W)) u_steer (
    .need_fill (need_fill),
    .flush     (flush),
    .prim_v    (prim_v),
    .prim_w    (prim_w),
    .sec_v     (sec_v),
    .sec_w     (sec_w),
    .sel       (sel),
    .fill_v    (fill_v),
    .fill_w    (fill_w),
    .take_prim (take_prim),
    .take_sec  (take_sec)
  );

  pq_decode_stage #(.W(W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .advance   (advance),
    .fill_v    (fill_v),
    .fill_w    (fill_w),
    .need_fill (need_fill),
    .dec_v     (dec_valid),
    .dec_w     (dec_word),
    .res_v     (res_valid),
    .res_w     (res_word)
  );

endmodule

// File: rtl/pq_checker.sv
module pq_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         fetch_valid,
  input logic         fetch_ready,
  input logic         fetch_wide,
  input logic         flush,
  input logic         advance,
  input logic         dec_valid,
  input logic [W-1:0] dec_word,
  input logic         res_valid,
  input logic [W-1:0] res_word,
  input logic         prim_v,
  input logic         sec_v
);

  assert_load_split_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready) |=> (prim_v && (sec_v == $past(fetch_wide))));

  assert_prim_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((!dec_valid || advance) && prim_v && sec_v && !flush) |=> (!prim_v && sec_v));

  assert_autofill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_valid && prim_v && !flush) |=> dec_valid);

  assert_advance_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && dec_valid && !flush) |=> (res_valid && res_word == $past(dec_word)));

  assert_adv_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !dec_valid && !flush) |=> ($stable(res_valid) && $stable(res_word)));

  assert_flush_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !fetch_valid) |=> (!dec_valid && !res_valid && fetch_ready));

  assert_flush_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && fetch_valid) |=> (prim_v && !dec_valid && !res_valid));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !flush && dec_valid) |=>
      (dec_valid && $stable(dec_word) && $stable(res_valid) && $stable(res_word)));

endmodule

bind pq_top pq_checker #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_valid (fetch_valid),
  .fetch_ready (fetch_ready),
  .fetch_wide  (fetch_wide),
  .flush       (flush),
  .advance     (advance),
  .dec_valid   (dec_valid),
  .dec_word    (dec_word),
  .res_valid   (res_valid),
  .res_word    (res_word),
  .prim_v      (prim_v),
  .sec_v       (sec_v)
);

// File: tb/sim_pq_top.sv
`timescale 1ns/1ps
module sim_pq_top;

  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fetch_valid = 1'b0;
  logic          fetch_wide = 1'b0;
  logic [2*W-1:0] fetch_data = '0;
  logic          flush = 1'b0;
  logic          advance = 1'b0;
  logic          fetch_ready, dec_valid, res_valid;
  logic [W-1:0]  dec_word, res_word;

  int applied = 0;
  int miscmp  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  pq_top #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_wide(fetch_wide), .fetch_data(fetch_data), .flush(flush), .advance(advance),
    .dec_valid(dec_valid), .dec_word(dec_word), .res_valid(res_valid), .res_word(res_word)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        fl;
    logic        adv;
    logic        fv;
    logic        fw;
    logic [31:0] data;
    logic        edv;
    logic [15:0] edec;
    logic        erv;
    logic [15:0] eres;
    logic        erdy;
  } vec_t;

  // State expected after the edge on which each vector is applied
  localparam vec_t VECS [0:17] = '{
    '{4'd3,  1'b0,1'b0,1'b1,1'b0,32'h0000_1111, 1'b0,16'h0000,1'b0,16'h0000,1'b0}, // R3 narrow load
    '{4'd5,  1'b0,1'b0,1'b0,1'b0,32'h0,         1'b1,16'h1111,1'b0,16'h0000,1'b1}, // R5 autofill
    '{4'd4,  1'b0,1'b0,1'b1,1'b1,32'hAAAA_BBBB, 1'b1,16'h1111,1'b0,16'h0000,1'b0}, // R4 pair load
    '{4'd2,  1'b0,1'b0,1'b1,1'b1,32'hDEAD_BEEF, 1'b1,16'h1111,1'b0,16'h0000,1'b0}, // R2 refused
    '{4'd6,  1'b0,1'b1,1'b0,1'b0,32'h0,         1'b1,16'hAAAA,1'b1,16'h1111,1'b0}, // R6 primary first
    '{4'd4,  1'b0,1'b1,1'b0,1'b0,32'h0,         1'b1,16'hBBBB,1'b1,16'hAAAA,1'b1}, // R4 secondary next
    '{4'd6,  1'b0,1'b1,1'b1,1'b0,32'h0000_2222, 1'b0,16'h0000,1'b1,16'hBBBB,1'b0}, // R6 advance+fetch
    '{4'd5,  1'b0,1'b0,1'b0,1'b0,32'h0,         1'b1,16'h2222,1'b1,16'hBBBB,1'b1}, // R5
    '{4'd6,  1'b0,1'b1,1'b0,1'b0,32'h0,         1'b0,16'h0000,1'b1,16'h2222,1'b1}, // R6 empties decode
    '{4'd7,  1'b0,1'b1,1'b0,1'b0,32'h0,         1'b0,16'h0000,1'b1,16'h2222,1'b1}, // R7 ignored
    '{4'd4,  1'b0,1'b0,1'b1,1'b1,32'h3333_4444, 1'b0,16'h0000,1'b1,16'h2222,1'b0}, // R4
    '{4'd4,  1'b0,1'b0,1'b0,1'b0,32'h0,         1'b1,16'h3333,1'b1,16'h2222,1'b0}, // R4 upper first
    '{4'd10, 1'b0,1'b0,1'b0,1'b0,32'h0,         1'b1,16'h3333,1'b1,16'h2222,1'b0}, // R10 hold
    '{4'd9,  1'b1,1'b0,1'b1,1'b1,32'h5555_6666, 1'b0,16'h0000,1'b0,16'h0000,1'b0}, // R9 flush+fetch
    '{4'd9,  1'b0,1'b0,1'b0,1'b0,32'h0,         1'b1,16'h5555,1'b0,16'h0000,1'b0}, // R9 survived
    '{4'd8,  1'b1,1'b0,1'b0,1'b0,32'h0,         1'b0,16'h0000,1'b0,16'h0000,1'b1}, // R8 flush
    '{4'd7,  1'b0,1'b1,1'b1,1'b0,32'h0000_7777, 1'b0,16'h0000,1'b0,16'h0000,1'b0}, // R7 adv on empty
    '{4'd3,  1'b0,1'b0,1'b0,1'b0,32'h0,         1'b1,16'h7777,1'b0,16'h0000,1'b1}  // R3
  };

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    applied++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] observed(input logic mdv, input logic mrv);
    return {1'b0, dec_valid, mdv ? dec_word : 16'h0, res_valid, mrv ? res_word : 16'h0, fetch_ready};
  endfunction

  task automatic idle_inputs();
    fetch_valid = 1'b0; fetch_wide = 1'b0; fetch_data = '0; flush = 1'b0; advance = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscmp++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", {1'b0, dec_valid, 16'h0, res_valid, 16'h0, fetch_ready}, {1'b0,1'b0,16'h0,1'b0,16'h0,1'b1});
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      flush = VECS[i].fl; advance = VECS[i].adv; fetch_valid = VECS[i].fv;
      fetch_wide = VECS[i].fw; fetch_data = VECS[i].data;
      @(posedge clk);
      #1 idle_inputs();
      #0.5;
      check($sformatf("R%0d vec %0d", VECS[i].req, i), observed(VECS[i].edv, VECS[i].erv),
            {1'b0, VECS[i].edv, VECS[i].edv ? VECS[i].edec : 16'h0,
             VECS[i].erv, VECS[i].erv ? VECS[i].eres : 16'h0, VECS[i].erdy});
    end

    // R2 / R9: ready rises with flush while the holding stage is full
    @(negedge clk);
    fetch_valid = 1'b1; fetch_wide = 1'b1; fetch_data = 32'h8888_9999;
    @(posedge clk); #1 idle_inputs();
    @(negedge clk);
    check("R2 ready low when full", {35'h0, fetch_ready}, 36'h0);
    flush = 1'b1; #0.5;
    check("R9 ready with flush", {35'h0, fetch_ready}, 36'h1);
    @(posedge clk); #1 idle_inputs(); #0.5;
    // R8 everything cleared
    check("R8 cleared", observed(1'b0, 1'b0), {1'b0,1'b0,16'h0,1'b0,16'h0,1'b1});

    // R1 reset in mid-run
    @(negedge clk);
    fetch_valid = 1'b1; fetch_data = 32'h0000_ABCD;
    @(posedge clk); #1 idle_inputs();
    @(posedge clk); #1;
    check("R3 decode before reset", {20'h0, dec_word}, {20'h0, 16'hABCD});
    @(negedge clk); rst_n = 1'b0; #0.5;
    check("R1 async reset", observed(1'b0, 1'b0), {1'b0,1'b0,16'h0,1'b0,16'h0,1'b1});
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
    $finish;
  end

endmodule